// File: doc/BRIEF.md
# Edge Trigger Filter

The block watches one asynchronous digital line and issues a one-clock trigger pulse when a clean rising edge arrives. The line first crosses into the clock domain through a two-flop synchronizer. A rising edge is accepted only when it falls outside the hold-off window of the previous accepted edge. The hold-off window is chosen by a 4-bit setting in steps of `HOLD_STEP` cycles. An accepted pulse must then stay high for a programmable minimum number of cycles before the trigger fires. A pulse that drops before that point is reported as a runt and produces no trigger.

Alongside, the block counts every synchronized rising edge, including those the hold-off ignores, over a sliding window of `WIN_CYC` cycles. When that count exceeds `BURST_LIMIT`, the line is treated as a noise burst. The burst flag then stays high until the count falls back, and no trigger is issued while it is high. All timing is counted in clock cycles. The block carries no data stream, so every pin is a plain level or a single-cycle pulse with no handshake.

Top module: `edge_trigger_filter`

## Requirements
- R1: During the first three clock edges after reset release, `trig_o` stays low. A line that is already high when reset is released produces no trigger.
- R2: Let `M` be the minimum width, where a setting of 0 counts as 1, and let edge 1 be the first clock edge that samples the line high. An accepted pulse that stays high for at least `M` sampled edges raises `trig_o` in the cycle after edge `M+2`.
- R3: Each qualified pulse produces exactly one trigger, one cycle wide, however long the pulse stays high.
- R4: An accepted pulse that is high for `W < M` sampled edges produces no trigger. It raises `runt_o` for one cycle after edge `W+3`.
- R5: The hold-off length is `N = (holdoff_sel_i + 1) * HOLD_STEP` cycles. A rising edge sampled `d` edges after an accepted one is ignored if `d <= N` and accepted if `d >= N+1`. An ignored edge gives neither a trigger nor a runt.
- R6: `burst_o` rises in the cycle after the clock edge at which the last `WIN_CYC` cycles hold more than `BURST_LIMIT` synchronized rising edges. Edges ignored by the hold-off are counted. The flag falls once the count is back at or below the limit.
- R7: No trigger is issued while `burst_o` is high, and none is issued at the clock edge that raises `burst_o`.
- R8: While reset is held, `trig_o`, `runt_o` and `burst_o` are low.
- R9: `trig_o` and `runt_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_i | input | 1 | Asynchronous line being watched |
| holdoff_sel_i | input | 4 | Hold-off length in steps, minus one |
| min_width_i | input | WIDTH_W | Minimum high width in cycles (0 acts as 1) |
| trig_o | output | 1 | One-cycle trigger pulse |
| runt_o | output | 1 | One-cycle runt pulse |
| burst_o | output | 1 | Noise burst flag |

## Verification
Counting from the first edge that samples the line high, a trigger is due after edge `M+2` and a runt after edge `W+3`. A burst flag is due one edge after the edge that brings in the rising edge over the limit. The bench changes `sig_i` one time unit after a rising clock edge and reads the outputs at the same offset after every edge. It records the index of the edge at which each output first rises and compares it with these formulas. Hold-off checks count triggers over a pair of pulses whose rising edges sit exactly `N` and `N+1` edges apart.

// File: rtl/edge_trig_pkg.sv
package edge_trig_pkg;
  // Hold-off length in cycles for a 4-bit step setting.
  function automatic int unsigned holdoff_len(input logic [3:0] sel, input int unsigned step);
    return (int'(sel) + 1) * step;
  endfunction
endpackage

// File: rtl/etf_sync.sv
module etf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o,
  output logic prev_o,
  output logic ready_o
);
  logic [STAGES:0] chain;
  logic [STAGES:0] fill;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '0;
      fill  <= '0;
    end else begin
      chain <= {chain[STAGES-1:0], d_i};
      fill  <= {fill[STAGES-1:0], 1'b1};
    end
  end

  assign q_o     = chain[STAGES-1];
  assign prev_o  = chain[STAGES];
  assign ready_o = fill[STAGES];
endmodule

// File: rtl/etf_holdoff.sv
module etf_holdoff
  import edge_trig_pkg::*;
#(
  parameter int HOLD_STEP = 4,
  localparam int HOLD_MAX = 16 * HOLD_STEP,
  localparam int HW       = $clog2(HOLD_MAX + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] sel_i,
  input  logic       load_i,
  output logic       open_o
);
  logic [HW-1:0] remain;
  logic [HW-1:0] load_val;

  assign load_val = HW'(holdoff_len(sel_i, HOLD_STEP));

  always_ff @(posedge clk) begin
    if (!rst_n)              remain <= '0;
    else if (load_i)         remain <= load_val;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign open_o = (remain == '0);
endmodule

// File: rtl/etf_burst.sv
module etf_burst #(
  parameter int WIN_CYC     = 32,
  parameter int BURST_LIMIT = 3,
  localparam int CW = $clog2(WIN_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  output logic hot_o,
  output logic flag_o
);
  logic [WIN_CYC-1:0] hist;
  logic [WIN_CYC-1:0] nxt;
  logic [CW-1:0]      cnt;

  assign nxt = {hist[WIN_CYC-2:0], edge_i};

  always_comb begin
    cnt = '0;
    for (int i = 0; i < WIN_CYC; i++) cnt = cnt + CW'(nxt[i]);
  end

  assign hot_o = (cnt > CW'(BURST_LIMIT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist   <= '0;
      flag_o <= 1'b0;
    end else begin
      hist   <= nxt;
      flag_o <= hot_o;
    end
  end
endmodule

// File: rtl/etf_width.sv
module etf_width #(
  parameter int WIDTH_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lvl_i,
  input  logic               start_i,
  input  logic [WIDTH_W-1:0] min_w_i,
  input  logic               block_i,
  output logic               trig_o,
  output logic               runt_o
);
  logic               meas;
  logic [WIDTH_W-1:0] len;
  logic [WIDTH_W-1:0] eff;
  logic [WIDTH_W-1:0] cur;
  logic               live;
  logic               hit;

  assign eff  = (min_w_i == '0) ? WIDTH_W'(1) : min_w_i;
  assign live = start_i | (meas & lvl_i);
  assign cur  = start_i ? WIDTH_W'(1) : len + 1'b1;
  assign hit  = live && (cur == eff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meas   <= 1'b0;
      len    <= '0;
      trig_o <= 1'b0;
      runt_o <= 1'b0;
    end else begin
      meas   <= live & ~hit;
      len    <= live ? cur : '0;
      trig_o <= hit & ~block_i;
      runt_o <= meas & ~lvl_i;
    end
  end
endmodule

// File: rtl/edge_trigger_filter.sv
module edge_trigger_filter #(
  parameter int HOLD_STEP   = 4,
  parameter int WIN_CYC     = 32,
  parameter int BURST_LIMIT = 3,
  parameter int WIDTH_W     = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sig_i,
  input  logic [3:0]         holdoff_sel_i,
  input  logic [WIDTH_W-1:0] min_width_i,
  output logic               trig_o,
  output logic               runt_o,
  output logic               burst_o
);
  logic lvl, lvl_prev, ready;
  logic rise, rise_ok, open, hot;

  etf_sync #(.STAGES(2)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(sig_i),
    .q_o(lvl), .prev_o(lvl_prev), .ready_o(ready)
  );

  assign rise    = lvl & ~lvl_prev & ready;
  assign rise_ok = rise & open;

  etf_holdoff #(.HOLD_STEP(HOLD_STEP)) hold_i (
    .clk(clk), .rst_n(rst_n), .sel_i(holdoff_sel_i),
    .load_i(rise_ok), .open_o(open)
  );

  etf_burst #(.WIN_CYC(WIN_CYC), .BURST_LIMIT(BURST_LIMIT)) burst_i (
    .clk(clk), .rst_n(rst_n), .edge_i(rise),
    .hot_o(hot), .flag_o(burst_o)
  );

  etf_width #(.WIDTH_W(WIDTH_W)) width_i (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .start_i(rise_ok),
    .min_w_i(min_width_i), .block_i(hot),
    .trig_o(trig_o), .runt_o(runt_o)
  );
endmodule

// File: rtl/edge_trigger_filter_chk.sv
module edge_trigger_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic trig_o,
  input logic runt_o,
  input logic burst_o
);
  logic [1:0] warm;

  always_ff @(posedge clk) begin
    if (!rst_n)             warm <= 2'd0;
    else if (warm != 2'd3)  warm <= warm + 2'd1;
  end

  // R1
  warmup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd3) |-> !trig_o);
  // R3
  trig_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);
  // R4
  runt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    runt_o |=> !runt_o);
  // R7
  trig_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> !burst_o);
  // R9
  trig_runt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(trig_o && runt_o));
endmodule

bind edge_trigger_filter edge_trigger_filter_chk chk_i (
  .clk(clk), .rst_n(rst_n), .trig_o(trig_o), .runt_o(runt_o), .burst_o(burst_o)
);

// File: tb/edge_trigger_filter_tb.sv
module edge_trigger_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // Columns: min width, high edges, expected kind (1 trigger, 2 runt), expected edge index
  localparam int VMIN [NVEC] = '{1, 1, 3, 3, 0, 15, 15, 2, 4, 6};
  localparam int VHI  [NVEC] = '{1, 5, 2, 3, 1, 15, 14, 10, 1, 5};
  localparam int VKND [NVEC] = '{1, 1, 2, 1, 1, 1, 2, 1, 2, 2};
  localparam int VLAT [NVEC] = '{3, 3, 5, 5, 3, 17, 17, 4, 4, 8};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sig = 1'b0;
  logic [3:0] sel = 4'd0;
  logic [3:0] minw = 4'd1;
  logic trig, runt, burst;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_trigger_filter dut_i (
    .clk(clk), .rst_n(rst_n), .sig_i(sig), .holdoff_sel_i(sel),
    .min_width_i(minw), .trig_o(trig), .runt_o(runt), .burst_o(burst)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One pulse: high for hi edges, then low for lo edges. Returns counts and first indices.
  task automatic pulse(input int mw, input int hi, input int lo,
                       output int nt, output int nr, output int tl, output int rl,
                       output int bl);
    nt = 0; nr = 0; tl = 0; rl = 0; bl = 0;
    minw = 4'(mw);
    sig = 1'b1;
    for (int i = 1; i <= hi + lo; i++) begin
      @(posedge clk); #1;
      if (trig) begin nt++; if (tl == 0) tl = i; end
      if (runt) begin nr++; if (rl == 0) rl = i; end
      if (burst && bl == 0) bl = i;
      if (i == hi) sig = 1'b0;
    end
  endtask

  task automatic idle(input int n, output int nt, output int nr);
    nt = 0; nr = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (trig) nt++;
      if (runt) nr++;
    end
  endtask

  initial begin
    int nt, nr, tl, rl, bl, st, sr;
    // R8: reset state
    repeat (3) @(posedge clk);
    #1;
    check(!trig && !runt && !burst, "R8", "outputs in reset", {trig, runt, burst}, 0);
    rst_n = 1'b1;
    idle(20, nt, nr);
    // R1: line high at reset release
    rst_n = 1'b0;
    sig = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(12, nt, nr);
    check(nt == 0, "R1", "trigger for line high at release", nt, 0);
    sig = 1'b0;
    idle(40, nt, nr);
    check(nt == 0 && nr == 0, "R1", "fall after release", nt + nr, 0);

    // Table walk: R2 and R4
    sel = 4'd0;
    for (int v = 0; v < NVEC; v++) begin
      pulse(VMIN[v], VHI[v], 80, nt, nr, tl, rl, bl);
      if (VKND[v] == 1)
        check(nt == 1 && nr == 0 && tl == VLAT[v], "R2", $sformatf("vector %0d trigger edge", v),
              tl * 100 + nt * 10 + nr, VLAT[v] * 100 + 10);
      else
        check(nr == 1 && nt == 0 && rl == VLAT[v], "R4", $sformatf("vector %0d runt edge", v),
              rl * 100 + nt * 10 + nr, VLAT[v] * 100 + 1);
    end
    // R3: long pulse gives one trigger
    pulse(2, 40, 60, nt, nr, tl, rl, bl);
    check(nt == 1, "R3", "triggers for long pulse", nt, 1);

    // R5: hold-off boundaries, step 4
    sel = 4'd0;
    pulse(2, 2, 2, nt, nr, tl, rl, bl); st = nt; sr = nr;
    pulse(2, 1, 80, nt, nr, tl, rl, bl); st += nt; sr += nr;
    check(st == 1 && sr == 0, "R5", "sel 0 gap 4 triggers/runts", st * 10 + sr, 10);
    pulse(2, 2, 3, nt, nr, tl, rl, bl); st = nt;
    pulse(2, 2, 80, nt, nr, tl, rl, bl); st += nt;
    check(st == 2, "R5", "sel 0 gap 5 triggers", st, 2);
    sel = 4'd1;
    pulse(2, 2, 6, nt, nr, tl, rl, bl); st = nt;
    pulse(2, 2, 80, nt, nr, tl, rl, bl); st += nt;
    check(st == 1, "R5", "sel 1 gap 8 triggers", st, 1);
    pulse(2, 2, 7, nt, nr, tl, rl, bl); st = nt;
    pulse(2, 2, 80, nt, nr, tl, rl, bl); st += nt;
    check(st == 2, "R5", "sel 1 gap 9 triggers", st, 2);
    sel = 4'd15;
    pulse(1, 1, 63, nt, nr, tl, rl, bl); st = nt;
    pulse(1, 1, 80, nt, nr, tl, rl, bl); st += nt;
    check(st == 1, "R5", "sel 15 gap 64 triggers", st, 1);
    pulse(1, 1, 64, nt, nr, tl, rl, bl); st = nt;
    pulse(1, 1, 80, nt, nr, tl, rl, bl); st += nt;
    check(st == 2, "R5", "sel 15 gap 65 triggers", st, 2);

    // R6 and R7: burst of five pulses, six edges apart
    sel = 4'd0;
    st = 0;
    for (int p = 1; p <= 5; p++) begin
      pulse(1, 1, 5, nt, nr, tl, rl, bl);
      st += nt;
      if (p <= 3) check(bl == 0, "R6", $sformatf("burst early on pulse %0d", p), bl, 0);
      if (p == 4) check(bl == 3, "R6", "burst rise edge on fourth pulse", bl, 3);
    end
    check(st == 3, "R7", "triggers during burst", st, 3);
    idle(40, nt, nr);
    check(!burst, "R6", "burst cleared after quiet", burst, 0);
    pulse(1, 1, 80, nt, nr, tl, rl, bl);
    check(nt == 1, "R7", "trigger after burst clears", nt, 1);
    // R6: ignored edges still count toward a burst
    sel = 4'd15;
    st = 0; sr = 0;
    for (int p = 1; p <= 4; p++) begin
      pulse(1, 1, 3, nt, nr, tl, rl, bl);
      st += nt;
      if (bl != 0) sr = 1;
    end
    check(st == 1 && sr == 1, "R6", "held-off edges counted", st * 10 + sr, 11);
    idle(80, nt, nr);
    check(!burst && !runt && !trig, "R9", "quiet outputs at end", {trig, runt, burst}, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule